// File: doc/BRIEF.md
# Escaped Serial Command Decoder

This block sits behind a byte-wide serial receiver. It splits the incoming byte stream into plain payload bytes and in-band control commands. One reserved escape value, 0xA5, marks a special pair. If the escape is followed by a second escape, the pair stands for one literal 0xA5 payload byte. If the escape is followed by any other byte, that byte is read as a command that sets or clears one of five control flags.

Payload bytes leave the block as a byte stream with a one-cycle valid strobe, one cycle after they arrive. A downstream memory-write parser takes that stream. The five flags are registered, one per output port: reset, trigger, arm, clock-manager control and start. Setting the reset flag also drops the other four flags. The command byte carries a flag index and an inverted set bit, so the pair 0xA5 0x00 asserts reset.

Top module: `esc_cmd_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `out_valid`, all five flags and any pending escape. After it, the next byte is treated as a fresh byte.
- R2: A byte other than 0xA5, accepted (`in_valid` high) while no escape is pending, appears on `out_byte` with `out_valid` high for exactly one cycle, starting the cycle after acceptance.
- R3: An accepted 0xA5 while no escape is pending produces no output. The escape stays pending through any number of cycles with `in_valid` low.
- R4: An accepted 0xA5 while an escape is pending delivers one 0xA5 payload byte on the next cycle and ends the escape. Four 0xA5 bytes in a row therefore give two payload bytes.
- R5: An accepted byte other than 0xA5 while an escape is pending is a command and is never forwarded. Bits [3:1] hold the flag index: 0 reset, 1 trigger, 2 arm, 3 clock-manager, 4 start. Bit 0 is the inverted value: 0 sets the flag, 1 clears it. Bits [7:4] must be zero. The flag takes its new value in the cycle after the command byte.
- R6: A command byte with an index of 5 to 7, or with any of bits [7:4] set, changes no flag and produces no output. The decoder returns to the no-escape state, so the following byte is plain data.
- R7: A command that sets the reset flag clears the trigger, arm, clock-manager and start flags on the same edge on which reset rises.
- R8: Bytes presented while `in_valid` is low have no effect. A 0xA5 present on `in_byte` with `in_valid` low does not start an escape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Received byte |
| out_valid | output | 1 | Payload byte strobe (registered) |
| out_byte | output | 8 | Payload byte (registered) |
| ctl_reset | output | 1 | Reset control flag |
| ctl_trigger | output | 1 | Trigger control flag |
| ctl_arm | output | 1 | Arm control flag |
| ctl_clkmgr | output | 1 | Clock-manager control flag |
| ctl_start | output | 1 | Start control flag |

## Verification
Two updates land on one clock edge when a reset-set command arrives while trigger, arm, clock-manager and start are all set. On that edge the reset flag rises and the other four flags fall. The bench first sets all four flags and then sends 0xA5 0x00. It judges the flags at the next sample against a model in which only reset stays high. A second collision comes from pulsing the synchronous reset while an escape is pending. The byte after the reset must then come out as plain data, not be taken as a command.

// File: rtl/esc_cmd_pkg.sv
package esc_cmd_pkg;
  localparam int unsigned NUM_CTL   = 5;
  localparam int unsigned RESET_IDX = 0;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ESC  = 1'b1
  } esc_state_e;
endpackage

// File: rtl/esc_cmd_classify.sv
module esc_cmd_classify #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_CTL = 5,
  localparam int unsigned IDX_W  = $clog2(NUM_CTL)
) (
  input  logic [DATA_W-1:0] code,
  output logic              cmd_ok,
  output logic [IDX_W-1:0]  cmd_idx,
  output logic              cmd_set
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CTL - 1);

  logic [DATA_W-IDX_W-2:0] upper;

  always_comb begin
    upper   = code[DATA_W-1:IDX_W+1];
    cmd_idx = code[IDX_W:1];
    cmd_set = ~code[0];
    cmd_ok  = (upper == '0) && (cmd_idx <= LAST_IDX);
  end
endmodule

// File: rtl/esc_fsm.sv
module esc_fsm
  import esc_cmd_pkg::*;
#(
  parameter int unsigned        DATA_W   = 8,
  parameter logic [DATA_W-1:0]  ESC_BYTE = DATA_W'(8'hA5)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte,
  output logic              cmd_stb,
  output logic              esc_pend
);
  esc_state_e state;

  assign esc_pend = (state == ST_ESC);
  assign cmd_stb  = esc_pend && in_valid && (in_byte != ESC_BYTE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        case (state)
          ST_IDLE: begin
            if (in_byte == ESC_BYTE) begin
              state <= ST_ESC;
            end else begin
              out_valid <= 1'b1;
              out_byte  <= in_byte;
            end
          end
          default: begin
            state <= ST_IDLE;
            if (in_byte == ESC_BYTE) begin
              out_valid <= 1'b1;
              out_byte  <= ESC_BYTE;
            end
          end
        endcase
      end
    end
  end

  assert_plain_forward_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !esc_pend && in_byte != ESC_BYTE) |=> (out_valid && out_byte == $past(in_byte)));

  assert_esc_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !esc_pend && in_byte == ESC_BYTE) |=> (!out_valid && esc_pend));

  assert_literal_esc_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && esc_pend && in_byte == ESC_BYTE) |=> (out_valid && out_byte == ESC_BYTE && !esc_pend));

  assert_cmd_not_forwarded_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |=> !out_valid);

  assert_idle_no_effect_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && esc_pend == $past(esc_pend)));
endmodule

// File: rtl/esc_flag_bank.sv
module esc_flag_bank
  import esc_cmd_pkg::*;
#(
  parameter int unsigned NUM_CTL = 5,
  localparam int unsigned IDX_W  = $clog2(NUM_CTL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_stb,
  input  logic               cmd_ok,
  input  logic [IDX_W-1:0]   cmd_idx,
  input  logic               cmd_set,
  output logic [NUM_CTL-1:0] flags
);
  logic reset_raise;

  assign reset_raise = cmd_stb && cmd_ok && cmd_set && (cmd_idx == IDX_W'(RESET_IDX));

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_flag
    logic hit;
    assign hit = cmd_stb && cmd_ok && (cmd_idx == IDX_W'(g));

    if (g == RESET_IDX) begin : g_master
      always_ff @(posedge clk) begin
        if (rst)      flags[g] <= 1'b0;
        else if (hit) flags[g] <= cmd_set;
      end
    end else begin : g_slave
      always_ff @(posedge clk) begin
        if (rst)              flags[g] <= 1'b0;
        else if (reset_raise) flags[g] <= 1'b0;
        else if (hit)         flags[g] <= cmd_set;
      end
    end

    assert_flag_update_R5: assert property (@(posedge clk) disable iff (rst)
      (hit && !reset_raise) |=> (flags[g] == $past(cmd_set)));
  end

  assert_reset_clears_others_R7: assert property (@(posedge clk) disable iff (rst)
    reset_raise |=> (flags == NUM_CTL'(1) << RESET_IDX));
endmodule

// File: rtl/esc_cmd_decoder.sv
module esc_cmd_decoder
  import esc_cmd_pkg::*;
#(
  parameter int unsigned       DATA_W   = 8,
  parameter logic [DATA_W-1:0] ESC_BYTE = DATA_W'(8'hA5)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte,
  output logic              ctl_reset,
  output logic              ctl_trigger,
  output logic              ctl_arm,
  output logic              ctl_clkmgr,
  output logic              ctl_start
);
  localparam int unsigned IDX_W = $clog2(NUM_CTL);

  logic               cmd_stb;
  logic               esc_pend;
  logic               cmd_ok;
  logic [IDX_W-1:0]   cmd_idx;
  logic               cmd_set;
  logic [NUM_CTL-1:0] flags;

  esc_fsm #(.DATA_W(DATA_W), .ESC_BYTE(ESC_BYTE)) u_fsm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte),
    .cmd_stb(cmd_stb), .esc_pend(esc_pend)
  );

  esc_cmd_classify #(.DATA_W(DATA_W), .NUM_CTL(NUM_CTL)) u_classify (
    .code(in_byte), .cmd_ok(cmd_ok), .cmd_idx(cmd_idx), .cmd_set(cmd_set)
  );

  esc_flag_bank #(.NUM_CTL(NUM_CTL)) u_flags (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_ok(cmd_ok),
    .cmd_idx(cmd_idx), .cmd_set(cmd_set), .flags(flags)
  );

  assign ctl_reset   = flags[0];
  assign ctl_trigger = flags[1];
  assign ctl_arm     = flags[2];
  assign ctl_clkmgr  = flags[3];
  assign ctl_start   = flags[4];

  assert_unknown_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && !cmd_ok) |=> ($stable(flags) && !out_valid && !esc_pend));

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && flags == '0 && !esc_pend));
endmodule

// File: tb/esc_cmd_decoder_tb.sv
module esc_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       ctl_reset, ctl_trigger, ctl_arm, ctl_clkmgr, ctl_start;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] expq[$];
  string      tagq[$];
  logic [4:0] exp_flags = 5'b0;
  bit         exp_pend  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  esc_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte),
    .ctl_reset(ctl_reset), .ctl_trigger(ctl_trigger), .ctl_arm(ctl_arm),
    .ctl_clkmgr(ctl_clkmgr), .ctl_start(ctl_start)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: applies one byte and pushes the expected payload into the scoreboard
  task automatic send(logic [7:0] b, string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    if (!exp_pend) begin
      if (b == 8'hA5) exp_pend = 1'b1;
      else begin expq.push_back(b); tagq.push_back(req); end
    end else begin
      exp_pend = 1'b0;
      if (b == 8'hA5) begin
        expq.push_back(8'hA5); tagq.push_back(req);
      end else if (b[7:4] == 4'h0 && b[3:1] < 3'd5) begin
        if (b[3:1] == 3'd0 && !b[0]) exp_flags = 5'b00001;
        else exp_flags[b[3:1]] = ~b[0];
      end
    end
  endtask

  task automatic idle(int n, logic [7:0] junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = junk;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    exp_pend = 1'b0; exp_flags = 5'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_flags(string req);
    check(req, {27'b0, ctl_start, ctl_clkmgr, ctl_arm, ctl_trigger, ctl_reset}, {27'b0, exp_flags});
  endtask

  // Monitor: pops the scoreboard whenever a payload byte appears
  always @(posedge clk) begin
    #1;
    if (!rst && out_valid) begin
      if (expq.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R2/R5: actual unexpected byte %0h expected no output", out_byte);
      end else begin
        check(tagq.pop_front(), {24'b0, out_byte}, {24'b0, expq.pop_front()});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    idle(1, 8'h00);
    check("R1 reset flags", {27'b0, ctl_start, ctl_clkmgr, ctl_arm, ctl_trigger, ctl_reset}, 0);
    check("R1 reset valid", {31'b0, out_valid}, 0);

    // R2 plain bytes back to back
    send(8'h11, "R2"); send(8'h22, "R2"); send(8'h00, "R2"); send(8'hFF, "R2");
    idle(2, 8'h00);

    // R3 escape held pending through idle cycles, R4 literal
    send(8'hA5, "R3");
    idle(3, 8'h00);
    check("R3 no output while pending", {31'b0, out_valid}, 0);
    send(8'hA5, "R4 literal");
    send(8'hA5, "R4"); send(8'hA5, "R4"); send(8'hA5, "R4"); send(8'hA5, "R4");
    idle(2, 8'h00);

    // R5 commands
    send(8'hA5, "R5"); send(8'h02, "R5"); idle(1, 8'h00); check_flags("R5 trigger set");
    send(8'hA5, "R5"); send(8'h04, "R5"); idle(1, 8'h00); check_flags("R5 arm set");
    send(8'hA5, "R5"); send(8'h06, "R5"); idle(1, 8'h00); check_flags("R5 clkmgr set");
    send(8'hA5, "R5"); send(8'h08, "R5"); idle(1, 8'h00); check_flags("R5 start set");
    send(8'hA5, "R5"); send(8'h05, "R5"); idle(1, 8'h00); check_flags("R5 arm clear");
    check("R5 arm low", {31'b0, ctl_arm}, 0);
    send(8'hA5, "R5"); send(8'h04, "R5"); idle(1, 8'h00); check_flags("R5 arm set again");

    // R6 unknown codes, next byte is data
    send(8'hA5, "R6"); send(8'h0A, "R6"); send(8'h33, "R6 after unknown");
    idle(1, 8'h00); check_flags("R6 idx5");
    send(8'hA5, "R6"); send(8'h10, "R6"); send(8'h34, "R6 after unknown");
    idle(1, 8'h00); check_flags("R6 upper bits");
    send(8'hA5, "R6"); send(8'hFF, "R6"); send(8'h35, "R6 after unknown");
    send(8'hA5, "R6"); send(8'h0F, "R6"); send(8'h36, "R6 after unknown");
    idle(2, 8'h00); check_flags("R6 idx7");

    // R7 reset set collides with clearing of the other flags
    check("R7 precondition", {27'b0, ctl_start, ctl_clkmgr, ctl_arm, ctl_trigger, ctl_reset}, 32'h1E);
    send(8'hA5, "R7"); send(8'h00, "R7"); idle(1, 8'h00); check_flags("R7 reset clears others");
    check("R7 only reset", {27'b0, ctl_start, ctl_clkmgr, ctl_arm, ctl_trigger, ctl_reset}, 32'h01);
    send(8'hA5, "R7"); send(8'h01, "R7"); idle(1, 8'h00); check_flags("R7 reset release");

    // R8 invalid cycles ignored, even an escape value on the bus
    idle(2, 8'hA5);
    send(8'h44, "R8 after invalid escape");
    idle(2, 8'h02);
    check_flags("R8 flags untouched");

    // R1 reset while an escape is pending
    send(8'hA5, "R1"); send(8'h02, "R1"); idle(1, 8'h00);
    send(8'hA5, "R1");
    do_reset();
    check_flags("R1 reset mid escape flags");
    send(8'h02, "R1 byte after reset is data");
    idle(3, 8'h00);
    check_flags("R1 no command after reset");

    check("R2 scoreboard drained", expq.size(), 0);
    done = 1'b1;
    summary();
  end
endmodule